// File: doc/BRIEF.md
# Accumulator Memory-Reference Execution Unit

This block is the execute engine of a small 12-bit accumulator machine. It holds the accumulator (AC), a one-bit link (L) and the program counter (PC). It fetches each instruction through a synchronous single-port memory interface and decodes its 3-bit opcode. It then runs the six memory-reference and jump operations: bitwise AND, two's-complement add, increment-and-skip-if-zero, deposit-and-clear, subroutine call and jump.

An effective address is formed from a 7-bit offset on page zero or on the page of the instruction. It may be direct, or indirect through a pointer word. Pointer words at addresses 0o10 to 0o17 are incremented before use. The two remaining opcodes are not executed here. They are announced for one cycle on an output so that an external unit can act on them, and the unit moves on to the next instruction.

A single interrupt line is honoured between instructions. It forces a subroutine call to address 0 and drops the interrupt enable. The enable is re-armed by a request pulse, but only after the next instruction has completed. A halt input freezes the unit at the next instruction boundary.

Top module: `acc_exec_unit`

## Requirements
- R1: While rst_ni is low and after its release, PC equals RESET_PC (0x080), and AC, L and the interrupt enable are 0.
- R2: Opcode 000 replaces AC with AC AND the operand word; L is unchanged.
- R3: Opcode 001 adds the operand to the 13-bit value {L,AC}: AC takes the low 12 bits of the sum, and L is inverted when the 12-bit add carries out.
- R4: Opcode 010 writes operand+1 back to the operand address; when that value is 0, the next instruction is skipped (PC advances by 2 instead of 1).
- R5: Opcode 011 writes AC to the operand address and then clears AC.
- R6: Opcode 100 writes the address of the following instruction into the target word and continues at target+1. Opcode 101 continues at the target.
- R7: Instruction bits 11:9 are the opcode, bit 8 selects indirect, bit 7 selects the page of the instruction's own address (bits 11:7) instead of page zero, and bits 6:0 are the offset. An indirect reference uses the word read at that address as the effective address.
- R8: An indirect reference whose pointer address lies in 0x008..0x00F first writes pointer+1 back to that address and uses the new value. Pointers at 0x007 and 0x010 are left unchanged.
- R9: At an instruction boundary with irq_i high, the enable set and halt_i low, the unit writes PC to address 0, continues at address 1 and clears the enable.
- R10: A pulse on ion_req_i sets the enable only when the next instruction started after the pulse has completed; during that instruction the enable still reads 0.
- R11: Opcodes 110 and 111 raise ext_valid_o for one cycle with the instruction on ext_instr_o. They leave AC and L unchanged and advance PC by 1.
- R12: halt_i high at an instruction boundary holds PC, AC and L and writes no memory; halt takes priority over a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Stop at the next instruction boundary |
| irq_i | input | 1 | Level interrupt request |
| ion_req_i | input | 1 | Pulse that re-arms the interrupt enable |
| mem_addr_o | output | 12 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 12 | Memory write data |
| mem_rdata_i | input | 12 | Read data, valid one cycle after the address |
| ext_valid_o | output | 1 | Instruction for the external unit is present |
| ext_instr_o | output | 12 | That instruction word |
| ac_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |
| pc_o | output | 12 | Program counter |
| ien_o | output | 1 | Interrupt enable |

## Verification
Two boundary events can land in the same cycle. Halt and a pending interrupt can meet at the same instruction boundary, and so can the completion of the armed instruction and an interrupt. The bench raises irq_i before the enable is re-armed, then holds halt_i just as the arming instruction ends. It then confirms three things: the enable reads 0 during that instruction and 1 afterwards, address 0 is untouched while halted, and the forced call happens only once halt_i drops, storing the correct return address.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  localparam int WORD_W = 12;
  localparam int OP_W   = 3;
  localparam int OFF_W  = 7;
  localparam int PAGE_W = WORD_W - OFF_W;
  localparam int IND_B  = OFF_W + 1;

  typedef enum logic [OP_W-1:0] {
    OP_AND, OP_TAD, OP_ISZ, OP_DCA, OP_JMS, OP_JMP, OP_IOT, OP_OPR
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_IND, S_RD, S_EXE
  } state_e;
endpackage

// File: rtl/acc_ea_gen.sv
`timescale 1ns/1ps
module acc_ea_gen import acc_pkg::*; #(
  parameter logic [WORD_W-1:0] AUTO_BASE = 12'h008,
  parameter int                AUTO_CNT  = 8
) (
  input  logic [IND_B:0]       instr_i,
  input  logic [PAGE_W-1:0]    page_i,
  output logic [WORD_W-1:0]    ea_o,
  output logic                 ind_o,
  output logic                 auto_o
);
  localparam logic [WORD_W:0] AUTO_END = {1'b0, AUTO_BASE} + (WORD_W+1)'(AUTO_CNT);

  assign ind_o  = instr_i[IND_B];
  assign ea_o   = instr_i[OFF_W] ? {page_i, instr_i[OFF_W-1:0]}
                                 : {{PAGE_W{1'b0}}, instr_i[OFF_W-1:0]};
  assign auto_o = (ea_o >= AUTO_BASE) && ({1'b0, ea_o} < AUTO_END);
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu import acc_pkg::*; (
  input  op_e               op_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              link_i,
  input  logic [WORD_W-1:0] opnd_i,
  output logic [WORD_W-1:0] ac_o,
  output logic              link_o,
  output logic [WORD_W-1:0] inc_o,
  output logic              inc_zero_o
);
  logic [WORD_W:0] sum;

  assign sum        = {1'b0, ac_i} + {1'b0, opnd_i};
  assign inc_o      = opnd_i + WORD_W'(1);
  assign inc_zero_o = (inc_o == '0);

  always_comb begin
    ac_o   = ac_i;
    link_o = link_i;
    case (op_i)
      OP_AND: ac_o = ac_i & opnd_i;
      OP_TAD: begin
        ac_o   = sum[WORD_W-1:0];
        link_o = link_i ^ sum[WORD_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_ion_ctl.sv
`timescale 1ns/1ps
module acc_ion_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ion_req_i,
  input  logic start_i,
  input  logic done_i,
  input  logic take_irq_i,
  output logic ien_o
);
  logic arm_q, run_q, ien_q;
  logic claim;

  // request seen before this instruction began: that instruction must finish first
  assign claim = start_i & arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      arm_q <= ion_req_i | (arm_q & ~start_i);
      if (take_irq_i) begin
        ien_q <= 1'b0;
        run_q <= 1'b0;
      end else if (done_i && (run_q || claim)) begin
        ien_q <= 1'b1;
        run_q <= 1'b0;
      end else if (claim) begin
        run_q <= 1'b1;
      end
    end
  end

  assign ien_o = ien_q;
endmodule

// File: rtl/acc_exec_unit.sv
`timescale 1ns/1ps
module acc_exec_unit import acc_pkg::*; #(
  parameter logic [WORD_W-1:0] RESET_PC  = 12'h080,
  parameter logic [WORD_W-1:0] AUTO_BASE = 12'h008,
  parameter int                AUTO_CNT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              irq_i,
  input  logic              ion_req_i,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              ext_valid_o,
  output logic [WORD_W-1:0] ext_instr_o,
  output logic [WORD_W-1:0] ac_o,
  output logic              link_o,
  output logic [WORD_W-1:0] pc_o,
  output logic              ien_o
);
  localparam logic [WORD_W-1:0] IRQ_VEC = '0;

  state_e            state_q, state_d;
  logic [WORD_W-1:0] pc_q, pc_d, ac_q, ac_d, ir_q, ir_d, ea_q, ea_d, ptr_q, ptr_d;
  logic              link_q, link_d, auto_q, auto_d;

  logic [WORD_W-1:0] instr_w, pc_inc, direct_ea, ref_ea, ret_pc;
  logic [WORD_W-1:0] alu_ac, inc_val;
  logic              alu_link, inc_zero, ind, is_auto, do_ref, take_irq;
  logic              ien, start, done;
  op_e               op_w, op_q;

  assign instr_w = (state_q == S_DECODE) ? mem_rdata_i : ir_q;
  assign op_w    = op_e'(instr_w[WORD_W-1 -: OP_W]);
  assign op_q    = op_e'(ir_q[WORD_W-1 -: OP_W]);
  assign pc_inc  = pc_q + WORD_W'(1);

  acc_ea_gen #(.AUTO_BASE(AUTO_BASE), .AUTO_CNT(AUTO_CNT)) u_ea (
    .instr_i (instr_w[IND_B:0]),
    .page_i  (pc_q[WORD_W-1 -: PAGE_W]),
    .ea_o    (direct_ea),
    .ind_o   (ind),
    .auto_o  (is_auto)
  );

  acc_alu u_alu (
    .op_i       (op_q),
    .ac_i       (ac_q),
    .link_i     (link_q),
    .opnd_i     (mem_rdata_i),
    .ac_o       (alu_ac),
    .link_o     (alu_link),
    .inc_o      (inc_val),
    .inc_zero_o (inc_zero)
  );

  assign start = (state_q == S_DECODE);
  assign done  = (state_q != S_FETCH) && (state_d == S_FETCH);

  acc_ion_ctl u_ion (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ion_req_i  (ion_req_i),
    .start_i    (start),
    .done_i     (done),
    .take_irq_i (take_irq),
    .ien_o      (ien)
  );

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    ac_d        = ac_q;
    link_d      = link_q;
    ir_d        = ir_q;
    ea_d        = ea_q;
    ptr_d       = ptr_q;
    auto_d      = auto_q;
    mem_addr_o  = pc_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = ac_q;
    ext_valid_o = 1'b0;
    take_irq    = 1'b0;
    do_ref      = 1'b0;
    ref_ea      = ea_q;
    ret_pc      = pc_q;

    case (state_q)
      S_FETCH: begin
        if (!halt_i) begin
          if (irq_i && ien) begin
            take_irq    = 1'b1;
            mem_addr_o  = IRQ_VEC;
            mem_we_o    = 1'b1;
            mem_wdata_o = pc_q;
            pc_d        = IRQ_VEC + WORD_W'(1);
          end else begin
            state_d = S_DECODE;
          end
        end
      end
      S_DECODE: begin
        ir_d = mem_rdata_i;
        pc_d = pc_inc;
        if (op_w == OP_IOT || op_w == OP_OPR) begin
          ext_valid_o = 1'b1;
          state_d     = S_FETCH;
        end else if (ind) begin
          mem_addr_o = direct_ea;
          ptr_d      = direct_ea;
          auto_d     = is_auto;
          state_d    = S_IND;
        end else begin
          do_ref = 1'b1;
          ref_ea = direct_ea;
          ret_pc = pc_inc;
        end
      end
      S_IND: begin
        ea_d = mem_rdata_i;
        if (auto_q) begin
          mem_addr_o  = ptr_q;
          mem_we_o    = 1'b1;
          mem_wdata_o = inc_val;
          ea_d        = inc_val;
        end
        state_d = S_RD;
      end
      S_RD: begin
        do_ref = 1'b1;
        ref_ea = ea_q;
        ret_pc = pc_q;
      end
      S_EXE: begin
        state_d = S_FETCH;
        case (op_q)
          OP_AND, OP_TAD: begin
            ac_d   = alu_ac;
            link_d = alu_link;
          end
          OP_ISZ: begin
            mem_addr_o  = ea_q;
            mem_we_o    = 1'b1;
            mem_wdata_o = inc_val;
            if (inc_zero) pc_d = pc_inc;
          end
          default: ;
        endcase
      end
      default: state_d = S_FETCH;
    endcase

    if (do_ref) begin
      state_d = S_FETCH;
      case (op_w)
        OP_AND, OP_TAD, OP_ISZ: begin
          mem_addr_o = ref_ea;
          ea_d       = ref_ea;
          state_d    = S_EXE;
        end
        OP_DCA: begin
          mem_addr_o  = ref_ea;
          mem_we_o    = 1'b1;
          mem_wdata_o = ac_q;
          ac_d        = '0;
        end
        OP_JMS: begin
          mem_addr_o  = ref_ea;
          mem_we_o    = 1'b1;
          mem_wdata_o = ret_pc;
          pc_d        = ref_ea + WORD_W'(1);
        end
        OP_JMP: pc_d = ref_ea;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      pc_q    <= RESET_PC;
      ac_q    <= '0;
      link_q  <= 1'b0;
      ir_q    <= '0;
      ea_q    <= '0;
      ptr_q   <= '0;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ac_q    <= ac_d;
      link_q  <= link_d;
      ir_q    <= ir_d;
      ea_q    <= ea_d;
      ptr_q   <= ptr_d;
      auto_q  <= auto_d;
    end
  end

  assign ext_instr_o = instr_w;
  assign ac_o        = ac_q;
  assign link_o      = link_q;
  assign pc_o        = pc_q;
  assign ien_o       = ien;
endmodule

// File: rtl/acc_exec_chk.sv
`timescale 1ns/1ps
module acc_exec_chk import acc_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic [2:0]        state_i,
  input logic [OP_W-1:0]   op_i,
  input logic [OP_W-1:0]   ir_op_i,
  input logic              take_irq_i,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic [WORD_W-1:0] mem_rdata_i,
  input logic              ext_valid_o,
  input logic [WORD_W-1:0] ac_o,
  input logic [WORD_W-1:0] pc_o,
  input logic              ien_o
);
  logic at_boundary;
  assign at_boundary = (state_i == S_FETCH);

  a_r12_halt_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_boundary && halt_i) |-> !mem_we_o);

  a_r12_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_boundary && halt_i) |=> ($stable(pc_o) && $stable(ac_o)));

  a_r9_irq_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |-> (mem_we_o && mem_addr_o == '0 && mem_wdata_o == pc_o));

  a_r9_irq_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |=> (pc_o == WORD_W'(1) && !ien_o));

  a_r4_isz_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_EXE && ir_op_i == OP_ISZ) |-> (mem_we_o && mem_wdata_o == mem_rdata_i + WORD_W'(1)));

  a_r5_dca_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == S_DECODE || state_i == S_RD) && op_i == OP_DCA && mem_we_o) |=> (ac_o == '0));

  a_r11_ext_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> !mem_we_o);

  a_r11_ext_keeps_ac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |=> $stable(ac_o));
endmodule

bind acc_exec_unit acc_exec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_i      (halt_i),
  .state_i     (state_q),
  .op_i        (op_w),
  .ir_op_i     (op_q),
  .take_irq_i  (take_irq),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .ext_valid_o (ext_valid_o),
  .ac_o        (ac_o),
  .pc_o        (pc_o),
  .ien_o       (ien_o)
);

// File: tb/tb_acc_exec_unit.sv
`timescale 1ns/1ps
module tb_acc_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] NOP = 12'hE00;

  typedef struct packed {
    logic [11:0] ac0;
    logic [11:0] ins;
    logic [11:0] opnd;
    logic [11:0] exp_ac;
    logic        exp_l;
    logic [11:0] exp_pc;
    logic [11:0] exp_mem;
    logic [3:0]  req;
  } vec_t;

  // load ac0 via TAD 0x040 at 0x080, test instruction at 0x081 on operand 0x041
  localparam vec_t VECS [9] = '{
    '{12'hF0F, 12'h041, 12'h3CC, 12'h30C, 1'b0, 12'h083, 12'h3CC, 4'd2}, // R2
    '{12'h123, 12'h241, 12'h456, 12'h579, 1'b0, 12'h083, 12'h456, 4'd3}, // R3
    '{12'hFFF, 12'h241, 12'h001, 12'h000, 1'b1, 12'h083, 12'h001, 4'd3}, // R3 carry
    '{12'h800, 12'h241, 12'h800, 12'h000, 1'b1, 12'h083, 12'h800, 4'd3}, // R3 carry
    '{12'h111, 12'h441, 12'h005, 12'h111, 1'b0, 12'h083, 12'h006, 4'd4}, // R4 no skip
    '{12'h111, 12'h441, 12'hFFF, 12'h111, 1'b0, 12'h084, 12'h000, 4'd4}, // R4 skip
    '{12'hABC, 12'h641, 12'h777, 12'h000, 1'b0, 12'h083, 12'hABC, 4'd5}, // R5
    '{12'h222, 12'hA41, 12'hE00, 12'h222, 1'b0, 12'h042, 12'hE00, 4'd6}, // R6 jump
    '{12'h333, 12'h841, 12'h000, 12'h333, 1'b0, 12'h043, 12'h082, 4'd6}  // R6 call
  };

  logic        clk = 1'b0;
  logic        rst_ni, halt_i, irq_i, ion_req_i;
  logic [11:0] mem_addr_o, mem_wdata_o, ext_instr_o, ac_o, pc_o;
  logic [11:0] mem_rdata;
  logic        mem_we_o, ext_valid_o, link_o, ien_o;
  logic [11:0] mem [4096];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_exec_unit dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .halt_i      (halt_i),
    .irq_i       (irq_i),
    .ion_req_i   (ion_req_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata),
    .ext_valid_o (ext_valid_o),
    .ext_instr_o (ext_instr_o),
    .ac_o        (ac_o),
    .link_o      (link_o),
    .pc_o        (pc_o),
    .ien_o       (ien_o)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_ni = 1'b0; halt_i = 1'b0; irq_i = 1'b0; ion_req_i = 1'b0;
    for (int a = 0; a < 4096; a++) mem[a] = NOP;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_ext(output logic [11:0] ins);
    int n = 0;
    while (!ext_valid_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!ext_valid_o) begin
      n_chk++; n_fail++;
      $display("FAIL timeout waiting for external opcode actual=0 expected=1");
    end
    ins = ext_instr_o;
  endtask

  task automatic run_to_halt();
    logic [11:0] ins;
    @(negedge clk);
    wait_ext(ins);
    halt_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] ins;

    // R1 reset state
    hold_reset();
    chk("R1 pc in reset", pc_o, 12'h080);
    halt_i = 1'b1;
    release_reset();
    repeat (3) @(negedge clk);
    chk("R1 pc", pc_o, 12'h080);
    chk("R1 ac", ac_o, 12'h000);
    chk("R1 link", {11'b0, link_o}, 12'h000);
    chk("R1 ien", {11'b0, ien_o}, 12'h000);
    chk("R1 no write", {11'b0, mem_we_o}, 12'h000);

    // table of single memory-reference instructions
    for (int i = 0; i < 9; i++) begin
      hold_reset();
      mem[12'h080] = 12'h240;
      mem[12'h040] = VECS[i].ac0;
      mem[12'h081] = VECS[i].ins;
      mem[12'h041] = VECS[i].opnd;
      release_reset();
      run_to_halt();
      chk($sformatf("R%0d vec%0d ac", VECS[i].req, i), ac_o, VECS[i].exp_ac);
      chk($sformatf("R%0d vec%0d link", VECS[i].req, i), {11'b0, link_o}, {11'b0, VECS[i].exp_l});
      chk($sformatf("R%0d vec%0d pc", VECS[i].req, i), pc_o, VECS[i].exp_pc);
      chk($sformatf("R%0d vec%0d mem", VECS[i].req, i), mem[12'h041], VECS[i].exp_mem);
    end

    // R7 indirect through page zero
    hold_reset();
    mem[12'h080] = 12'h341;
    mem[12'h041] = 12'h060;
    mem[12'h060] = 12'h123;
    release_reset();
    run_to_halt();
    chk("R7 indirect ac", ac_o, 12'h123);
    chk("R7 indirect pc", pc_o, 12'h082);

    // R7 current page, offset 0x10 on page 1 is 0x090
    hold_reset();
    mem[12'h080] = 12'h290;
    mem[12'h090] = 12'h321;
    mem[12'h010] = 12'h777;
    release_reset();
    run_to_halt();
    chk("R7 current page ac", ac_o, 12'h321);

    // R8 auto-increment window and its edges
    hold_reset();
    mem[12'h080] = 12'h30A;
    mem[12'h00A] = 12'h05F;
    mem[12'h060] = 12'h456;
    mem[12'h081] = 12'h310;
    mem[12'h010] = 12'h061;
    mem[12'h061] = 12'h0AA;
    mem[12'h082] = 12'h307;
    mem[12'h007] = 12'h05E;
    mem[12'h05E] = 12'h011;
    release_reset();
    run_to_halt();
    chk("R8 ac sum", ac_o, 12'h511);
    chk("R8 pointer 0x00A incremented", mem[12'h00A], 12'h060);
    chk("R8 pointer 0x010 kept", mem[12'h010], 12'h061);
    chk("R8 pointer 0x007 kept", mem[12'h007], 12'h05E);
    chk("R8 pc", pc_o, 12'h084);

    // R11 external opcode
    hold_reset();
    mem[12'h080] = 12'h240;
    mem[12'h040] = 12'h5A5;
    mem[12'h081] = 12'hC05;
    release_reset();
    @(negedge clk);
    wait_ext(ins);
    chk("R11 ext instr", ins, 12'hC05);
    @(negedge clk);
    chk("R11 single pulse", {11'b0, ext_valid_o}, 12'h000);
    wait_ext(ins);
    halt_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ac kept", ac_o, 12'h5A5);
    chk("R11 link kept", {11'b0, link_o}, 12'h000);
    chk("R11 pc", pc_o, 12'h083);

    // R10 delayed enable, R12 halt over interrupt, R9 entry
    hold_reset();
    irq_i = 1'b1;
    release_reset();
    ion_req_i = 1'b1;
    @(negedge clk);
    ion_req_i = 1'b0;
    wait_ext(ins);
    chk("R10 ien low during armed instr", {11'b0, ien_o}, 12'h000);
    halt_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 ien set after instr", {11'b0, ien_o}, 12'h001);
    chk("R12 pc held", pc_o, 12'h081);
    chk("R12 no vector write", mem[12'h000], NOP);
    halt_i = 1'b0;
    @(negedge clk);
    wait_ext(ins);
    halt_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 return stored", mem[12'h000], 12'h081);
    chk("R9 pc", pc_o, 12'h002);
    chk("R9 ien cleared", {11'b0, ien_o}, 12'h000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule